// File: doc/BRIEF.md
# Dependence-Steered Queue Scheduler

This block stands in for a central out-of-order issue window. Renamed instructions, each with two physical source tags and one physical destination tag, arrive one per cycle and first pass through a single-entry steering register. In that stage a placement heuristic picks one of several small in-order queues and pushes the instruction into it. The aim is to put chains of dependent instructions into the same queue, so that each queue drains roughly in dependence order. Only the oldest entry of each queue is ever looked at for issue, which keeps the wakeup and select logic small.

The block keeps two per-physical-register tables. A ready scoreboard is cleared when an instruction naming that register as its destination is pushed, and it is set by a writeback broadcast. A producer table records which queue holds the writer of a register, but only while that writer is still the youngest entry of its queue and has not issued. A downstream writeback source feeds `wbValid`/`wbTag`. The issue outputs give the winning queue and the destination tag for each issue slot.

Top module: `fifo_steer_sched`

## Requirements
- R1: After reset, `inReady` is 1, `steerFire` is 0, all `issueValid` bits are 0, every queue is empty and every physical register reads as ready.
- R2: An instruction accepted at a clock edge (`inValid` and `inReady` high) is in the steering stage during the following cycle. In that cycle `steerFire` is 1 if it is placed, and `steerQueue` gives the chosen queue. It is written into that queue at the end of the cycle.
- R3: If neither source has a chainable producer, the instruction is sent to the lowest-numbered queue that holds zero entries at the start of the steering cycle. A source is chainable when its register is not ready and its producer is recorded as the youngest entry of a queue.
- R4: If the left source (`inSrcA`) is chainable, the instruction is placed in the queue that holds that producer.
- R5: If the producer of a not-ready source already has a younger instruction behind it in its queue, that source is not chainable, and the instruction falls through to the next rule.
- R6: If the left source is not chainable and the right source (`inSrcB`) is, the instruction goes to the right producer's queue.
- R7: If both sources are chainable, the left producer's queue is chosen.
- R8: If an empty queue is needed and none holds zero entries at the start of the cycle, steering stalls. `steerFire` is 0 and `inReady` is 0, and the held instruction is placed in a later cycle once a queue has drained.
- R9: If the chosen producer queue already holds its full depth of entries, steering stalls even if other queues are empty. It places the instruction in that queue once the queue has room.
- R10: Only the oldest entry of a queue may issue, and only when both of its source registers read ready. A writeback sets ready from the next cycle on. Pushing an instruction clears the ready bit of its destination.
- R11: At most `ISSUE_W` (2) instructions issue per cycle, one per queue. Among ready queue heads the lowest-numbered queues win, and slot 0 carries the lower queue number.
- R12: Once a producer has issued, it is no longer chainable. A consumer of its still-pending result is steered as in R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Renamed instruction offered |
| inReady | output | 1 | Steering register can take an instruction this cycle |
| inSrcA | input | 6 | Left physical source tag |
| inSrcB | input | 6 | Right physical source tag |
| inDst | input | 6 | Physical destination tag |
| wbValid | input | 1 | Writeback broadcast valid |
| wbTag | input | 6 | Physical register made ready by the writeback |
| steerFire | output | 1 | Steering stage places its instruction this cycle |
| steerQueue | output | 2 | Queue chosen by the steering stage |
| issueValid | output | 2 | One bit per issue slot |
| issueQueue | output | 2x2 | Queue number issued in each slot |
| issueDst | output | 2x6 | Destination tag of the instruction in each slot |

## Verification
The checker assumes a correctly working rename stage in front of the block. It also assumes that no physical register is handed out as a destination again while an older writer of it is still in flight, and that writebacks only name registers whose writer has already issued. The directed stimulus uses a fresh destination tag for every instruction within a scenario and resets between scenarios. It broadcasts a writeback only for producers that the bench has already seen leave on an issue slot. Register 0 to 3 always serve as already-ready operands.

// File: rtl/sched_pkg.sv
package sched_pkg;
  localparam int NUM_Q    = 4;
  localparam int Q_DEPTH  = 4;
  localparam int NUM_PREG = 64;
  localparam int ISSUE_W  = 2;

  localparam int QW  = $clog2(NUM_Q);
  localparam int PW  = $clog2(NUM_PREG);
  localparam int CW  = $clog2(Q_DEPTH + 1);
  localparam int PTW = $clog2(Q_DEPTH);

  typedef struct packed {
    logic [PW-1:0] srcA;
    logic [PW-1:0] srcB;
    logic [PW-1:0] dst;
  } instr_t;

  typedef struct packed {
    logic          valid;
    logic [QW-1:0] q;
  } prod_t;

  typedef struct packed {
    logic             acceptIn;
    logic             push;
    logic [QW-1:0]    pushQ;
    logic [NUM_Q-1:0] pop;
  } strobe_t;
endpackage

// File: rtl/sched_queue.sv
module sched_queue
  import sched_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          push,
  input  logic          pop,
  input  instr_t        wrData,
  output instr_t        head,
  output logic [CW-1:0] count
);
  instr_t mem [Q_DEPTH];
  logic [PTW-1:0] rdPtr, wrPtr;

  function automatic logic [PTW-1:0] bump(input logic [PTW-1:0] p);
    return (p == PTW'(Q_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (push) begin
        mem[wrPtr] <= wrData;
        wrPtr      <= bump(wrPtr);
      end
      if (pop) rdPtr <= bump(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head = mem[rdPtr];
endmodule

// File: rtl/sched_datapath.sv
module sched_datapath
  import sched_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       strb,
  input  logic          inValid,
  input  instr_t        inInstr,
  input  logic          wbValid,
  input  logic [PW-1:0] wbTag,
  output logic          steerValid,
  output instr_t        steerInstr,
  output logic          srcAReady,
  output logic          srcBReady,
  output prod_t         prodA,
  output prod_t         prodB,
  output logic [CW-1:0] qCount [NUM_Q],
  output logic          headOk [NUM_Q],
  output logic [PW-1:0] headDst [NUM_Q]
);
  logic [NUM_PREG-1:0] sbReady;
  prod_t               prodTbl [NUM_PREG];
  instr_t              heads   [NUM_Q];

  // steering stage register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      steerValid <= 1'b0;
      steerInstr <= '0;
    end else if (strb.acceptIn) begin
      steerValid <= inValid;
      if (inValid) steerInstr <= inInstr;
    end
  end

  // ready scoreboard: a push clears the destination, a writeback sets it
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sbReady <= '1;
    end else begin
      if (strb.push) sbReady[steerInstr.dst] <= 1'b0;
      if (wbValid)   sbReady[wbTag]          <= 1'b1;
    end
  end

  // producer table: valid only while the writer is the youngest, unissued entry
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int p = 0; p < NUM_PREG; p++) prodTbl[p] <= '0;
    end else begin
      for (int p = 0; p < NUM_PREG; p++) begin
        if (prodTbl[p].valid) begin
          if (strb.push && prodTbl[p].q == strb.pushQ)
            prodTbl[p].valid <= 1'b0;
          if (strb.pop[prodTbl[p].q] && heads[prodTbl[p].q].dst == PW'(p))
            prodTbl[p].valid <= 1'b0;
        end
      end
      if (strb.push) prodTbl[steerInstr.dst] <= '{valid: 1'b1, q: strb.pushQ};
    end
  end

  for (genvar g = 0; g < NUM_Q; g++) begin : g_queue
    sched_queue u_queue (
      .clk    (clk),
      .rstN   (rstN),
      .push   (strb.push && strb.pushQ == QW'(g)),
      .pop    (strb.pop[g]),
      .wrData (steerInstr),
      .head   (heads[g]),
      .count  (qCount[g])
    );
    assign headOk[g]  = sbReady[heads[g].srcA] && sbReady[heads[g].srcB];
    assign headDst[g] = heads[g].dst;
  end

  assign srcAReady = sbReady[steerInstr.srcA];
  assign srcBReady = sbReady[steerInstr.srcB];
  assign prodA     = prodTbl[steerInstr.srcA];
  assign prodB     = prodTbl[steerInstr.srcB];
endmodule

// File: rtl/sched_control.sv
module sched_control
  import sched_pkg::*;
(
  input  logic          steerValid,
  input  logic          srcAReady,
  input  logic          srcBReady,
  input  prod_t         prodA,
  input  prod_t         prodB,
  input  logic [CW-1:0] qCount [NUM_Q],
  input  logic          headOk [NUM_Q],
  input  logic [PW-1:0] headDst [NUM_Q],
  output strobe_t       strb,
  output logic                         inReady,
  output logic                         steerFire,
  output logic [QW-1:0]                steerQueue,
  output logic [ISSUE_W-1:0]           issueValid,
  output logic [ISSUE_W-1:0][QW-1:0]   issueQueue,
  output logic [ISSUE_W-1:0][PW-1:0]   issueDst
);
  logic          chainA, chainB, emptyAny, canGo;
  logic [QW-1:0] emptyQ, target;
  logic [NUM_Q-1:0] avail;

  assign chainA = !srcAReady && prodA.valid;
  assign chainB = !srcBReady && prodB.valid;

  always_comb begin
    emptyAny = 1'b0;
    emptyQ   = '0;
    for (int q = NUM_Q - 1; q >= 0; q--) begin
      if (qCount[q] == '0) begin
        emptyAny = 1'b1;
        emptyQ   = QW'(q);
      end
    end
  end

  always_comb begin
    if (chainA) begin
      target = prodA.q;
      canGo  = qCount[prodA.q] != CW'(Q_DEPTH);
    end else if (chainB) begin
      target = prodB.q;
      canGo  = qCount[prodB.q] != CW'(Q_DEPTH);
    end else begin
      target = emptyQ;
      canGo  = emptyAny;
    end
  end

  assign steerFire = steerValid && canGo;
  assign steerQueue = target;
  assign inReady   = !steerValid || steerFire;

  // head select: lowest-numbered ready heads fill the slots in order
  always_comb begin
    for (int q = 0; q < NUM_Q; q++) avail[q] = (qCount[q] != '0) && headOk[q];
    strb.pop   = '0;
    issueValid = '0;
    issueQueue = '0;
    for (int k = 0; k < ISSUE_W; k++) begin
      for (int q = 0; q < NUM_Q; q++) begin
        if (!issueValid[k] && avail[q]) begin
          issueValid[k] = 1'b1;
          issueQueue[k] = QW'(q);
        end
      end
      if (issueValid[k]) begin
        avail[issueQueue[k]]    = 1'b0;
        strb.pop[issueQueue[k]] = 1'b1;
      end
    end
  end

  always_comb begin
    for (int k = 0; k < ISSUE_W; k++) issueDst[k] = headDst[issueQueue[k]];
  end

  assign strb.acceptIn = inReady;
  assign strb.push     = steerFire;
  assign strb.pushQ    = target;
endmodule

// File: rtl/fifo_steer_sched.sv
module fifo_steer_sched
  import sched_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       inValid,
  output logic                       inReady,
  input  logic [PW-1:0]              inSrcA,
  input  logic [PW-1:0]              inSrcB,
  input  logic [PW-1:0]              inDst,
  input  logic                       wbValid,
  input  logic [PW-1:0]              wbTag,
  output logic                       steerFire,
  output logic [QW-1:0]              steerQueue,
  output logic [ISSUE_W-1:0]         issueValid,
  output logic [ISSUE_W-1:0][QW-1:0] issueQueue,
  output logic [ISSUE_W-1:0][PW-1:0] issueDst
);
  strobe_t       strb;
  logic          steerValid, srcAReady, srcBReady;
  instr_t        steerInstr;
  prod_t         prodA, prodB;
  logic [CW-1:0] qCount [NUM_Q];
  logic          headOk [NUM_Q];
  logic [PW-1:0] headDst [NUM_Q];

  sched_datapath u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .inValid    (inValid),
    .inInstr    ('{srcA: inSrcA, srcB: inSrcB, dst: inDst}),
    .wbValid    (wbValid),
    .wbTag      (wbTag),
    .steerValid (steerValid),
    .steerInstr (steerInstr),
    .srcAReady  (srcAReady),
    .srcBReady  (srcBReady),
    .prodA      (prodA),
    .prodB      (prodB),
    .qCount     (qCount),
    .headOk     (headOk),
    .headDst    (headDst)
  );

  sched_control u_ctl (
    .steerValid (steerValid),
    .srcAReady  (srcAReady),
    .srcBReady  (srcBReady),
    .prodA      (prodA),
    .prodB      (prodB),
    .qCount     (qCount),
    .headOk     (headOk),
    .headDst    (headDst),
    .strb       (strb),
    .inReady    (inReady),
    .steerFire  (steerFire),
    .steerQueue (steerQueue),
    .issueValid (issueValid),
    .issueQueue (issueQueue),
    .issueDst   (issueDst)
  );
endmodule

// File: rtl/fifo_steer_sched_chk.sv
module fifo_steer_sched_chk
  import sched_pkg::*;
(
  input logic                       clk,
  input logic                       rstN,
  input logic                       inValid,
  input logic                       inReady,
  input logic                       steerValid,
  input instr_t                     steerInstr,
  input logic                       steerFire,
  input logic [QW-1:0]              steerQueue,
  input logic [CW-1:0]              qCount [NUM_Q],
  input logic                       headOk [NUM_Q],
  input logic [ISSUE_W-1:0]         issueValid,
  input logic [ISSUE_W-1:0][QW-1:0] issueQueue
);
  // R2: an accepted instruction occupies the steering stage next cycle
  a_r2_accept_loads: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady |=> steerValid);

  // R8: a stalled instruction stays put, unchanged
  a_r8_stall_holds: assert property (@(posedge clk) disable iff (!rstN)
    steerValid && !steerFire |=> steerValid && $stable(steerInstr));

  // R9: never push into a full queue
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    steerFire |-> qCount[steerQueue] != CW'(Q_DEPTH));

  for (genvar k = 0; k < ISSUE_W; k++) begin : g_slot
    // R10: an issued head exists and has both operands ready
    a_r10_head_ready: assert property (@(posedge clk) disable iff (!rstN)
      issueValid[k] |-> qCount[issueQueue[k]] != '0 && headOk[issueQueue[k]]);
    if (k > 0) begin : g_order
      // R11: slots fill in order with strictly increasing queue numbers
      a_r11_slot_order: assert property (@(posedge clk) disable iff (!rstN)
        issueValid[k] |-> issueValid[k-1] && issueQueue[k] > issueQueue[k-1]);
    end
  end
endmodule

bind fifo_steer_sched fifo_steer_sched_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .inValid    (inValid),
  .inReady    (inReady),
  .steerValid (steerValid),
  .steerInstr (steerInstr),
  .steerFire  (steerFire),
  .steerQueue (steerQueue),
  .qCount     (qCount),
  .headOk     (headOk),
  .issueValid (issueValid),
  .issueQueue (issueQueue)
);

// File: tb/test_fifo_steer_sched.sv
module test_fifo_steer_sched;
  import sched_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic inReady;
  logic [PW-1:0] inSrcA = '0, inSrcB = '0, inDst = '0;
  logic wbValid = 1'b0;
  logic [PW-1:0] wbTag = '0;
  logic steerFire;
  logic [QW-1:0] steerQueue;
  logic [ISSUE_W-1:0] issueValid;
  logic [ISSUE_W-1:0][QW-1:0] issueQueue;
  logic [ISSUE_W-1:0][PW-1:0] issueDst;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  fifo_steer_sched i_fifo_steer_sched (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inSrcA(inSrcA), .inSrcB(inSrcB), .inDst(inDst),
    .wbValid(wbValid), .wbTag(wbTag),
    .steerFire(steerFire), .steerQueue(steerQueue),
    .issueValid(issueValid), .issueQueue(issueQueue), .issueDst(issueDst)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; inValid = 1'b0; wbValid = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // offer one instruction; check the steering outcome in the following cycle
  task automatic send(input int a, input int b, input int d,
                      input int expFire, input int expQ, input string req);
    inValid = 1'b1; inSrcA = PW'(a); inSrcB = PW'(b); inDst = PW'(d);
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    chk({req, " fire"}, int'(steerFire), expFire);
    if (expFire != 0) chk({req, " queue"}, int'(steerQueue), expQ);
  endtask

  task automatic wb(input int t);
    wbValid = 1'b1; wbTag = PW'(t);
    @(negedge clk);
    wbValid = 1'b0;
  endtask

  task automatic slot(input string req, input int k, input int q, input int d);
    chk({req, " slot valid"}, int'(issueValid[k]), 1);
    chk({req, " slot queue"}, int'(issueQueue[k]), q);
    chk({req, " slot dst"}, int'(issueDst[k]), d);
  endtask

  task automatic testResetAndBasic();
    doReset();
    chk("R1 inReady", int'(inReady), 1);
    chk("R1 steerFire", int'(steerFire), 0);
    chk("R1 issueValid", int'(issueValid), 0);
    send(1, 2, 10, 1, 0, "R2 R3 ready ops to lowest empty");
    idle(1);
    slot("R10 ready head issues", 0, 0, 10);
    chk("R11 single issue", int'(issueValid[1]), 0);
  endtask

  task automatic testChaining();
    doReset();
    send(1, 2, 40, 1, 0, "R3 seed");
    idle(2);
    send(40, 1, 41, 1, 0, "R12 issued producer not chained");
    send(41, 2, 42, 1, 0, "R4 left tail chain");
    send(41, 3, 43, 1, 1, "R5 non-tail producer to empty");
    send(2, 43, 44, 1, 1, "R6 right tail chain");
    send(42, 44, 45, 1, 0, "R7 left wins");
    idle(1);
    chk("R10 pending heads wait", int'(issueValid), 0);
    wb(40);
    slot("R10 wakeup head", 0, 0, 41);
    chk("R10 entry behind head held", int'(issueValid[1]), 0);
    wb(41);
    slot("R11 two heads slot0", 0, 0, 42);
    slot("R11 two heads slot1", 1, 1, 43);
    wb(43);
    slot("R10 fifo order", 0, 1, 44);
    chk("R10 waiting head", int'(issueValid[1]), 0);
  endtask

  task automatic testNoEmpty();
    doReset();
    send(1, 2, 50, 1, 0, "R3 seed");
    idle(2);
    for (int i = 0; i < NUM_Q; i++)
      send(50, 1, 51 + i, 1, i, "R3 spread to empty");
    send(50, 1, 55, 0, 0, "R8 no empty queue");
    chk("R8 inReady low", int'(inReady), 0);
    idle(1);
    chk("R8 still stalled", int'(steerFire), 0);
    wb(50);
    slot("R11 lowest wins slot0", 0, 0, 51);
    slot("R11 lowest wins slot1", 1, 1, 52);
    chk("R8 start-of-cycle empty", int'(steerFire), 0);
    idle(1);
    chk("R8 resumes fire", int'(steerFire), 1);
    chk("R8 resumes queue", int'(steerQueue), 0);
    slot("R11 next slot0", 0, 2, 53);
    slot("R11 next slot1", 1, 3, 54);
  endtask

  task automatic testFullTarget();
    doReset();
    send(1, 2, 60, 1, 0, "R3 seed");
    idle(2);
    send(60, 1, 61, 1, 0, "R12 issued producer not chained");
    send(61, 1, 62, 1, 0, "R4 chain");
    send(62, 1, 63, 1, 0, "R4 chain");
    send(63, 1, 64, 1, 0, "R4 chain fills");
    send(64, 1, 65, 0, 0, "R9 full target stalls");
    chk("R9 inReady low", int'(inReady), 0);
    wb(60);
    slot("R10 head of full queue", 0, 0, 61);
    chk("R9 still full", int'(steerFire), 0);
    idle(1);
    chk("R9 resumes fire", int'(steerFire), 1);
    chk("R9 resumes queue", int'(steerQueue), 0);
  endtask

  initial begin
    testResetAndBasic();
    testChaining();
    testNoEmpty();
    testFullTarget();
    idle(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule